// File: doc/BRIEF.md
# In-Array Row Copy DRAM Bank

This block models one DRAM bank whose rows can be copied into other rows without the data ever reaching the external column port. It holds the cell array and a row latch that an activation fills from the addressed row. The column port reads and writes the latch, and a restore strobe writes the latch back into the open row. A second row-wide register, the snapshot buffer, and a write-back selector are added on top of that normal access path.

A copy takes two activate/restore pairs. The first activation is made with the copy-select line high. It captures the source row into both the latch and the snapshot buffer. The restore that follows refreshes the source row from the latch. The second activation opens the destination row. A restore made with copy-select high then steers the snapshot buffer, not the latch, into the destination row, and a one-cycle done pulse follows. If the destination equals the source, the copy is refused with an error pulse, and the array keeps its contents.

Top module: `rowcopy_dram_bank`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `col_rdata_o`, `cpy_done_o` and `cpy_err_o` are all zero.
- R2: An activation (`ras_i` high) loads the row latch from row `row_addr_i`. A column read request returns the latch bits `[c*COL_W +: COL_W]` for `c = col_addr_i` on `col_rdata_o` in the following cycle, and `col_rdata_o` changes only after a read request.
- R3: Column writes change only the latch. A row in the array is updated only by a restore (`rw_i` high). Re-activating a row without a restore discards the column edits.
- R4: An activation with `ws_i` high starts a copy: the latch and the snapshot buffer both take the source row. The next restore writes the latch, including any column edits, back into the source row.
- R5: After the source restore, activating a different row and then restoring with `ws_i` high writes the snapshot buffer into that destination row. The destination receives the source contents as they were at the source activation. No other row changes.
- R6: A successful copy raises `cpy_done_o` for exactly one cycle, in the cycle after the cycle in which the destination write-back takes place.
- R7: If the destination activation addresses the source row, `cpy_err_o` pulses for one cycle in the next cycle and the copy is abandoned. The following `ws_i`-high restore writes the latch back, leaves the array unchanged and raises no done. A valid copy raises no error.
- R8: In the destination phase, a restore with `ws_i` low writes the latch, including column edits, into the destination row, ends the copy and raises no done.
- R9: Outside the destination phase, a restore with `ws_i` high behaves as a normal latch write-back and raises no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_addr_i | input | RAW | Row addressed by an activation |
| ras_i | input | 1 | Activate strobe: load latch from addressed row |
| rw_i | input | 1 | Restore strobe: write back to the open row |
| ws_i | input | 1 | Copy select: marks source activation and buffer write-back |
| col_addr_i | input | CAW | Column index within the latch |
| col_rd_i | input | 1 | Column read request |
| col_wr_i | input | 1 | Column write request |
| col_wdata_i | input | COL_W | Column write data |
| col_rdata_o | output | COL_W | Registered column read data |
| cpy_done_o | output | 1 | One-cycle copy completion pulse |
| cpy_err_o | output | 1 | One-cycle pulse for a refused copy |

## Verification
The bench uses the default parameters: sixteen rows of sixteen bits, split into four 4-bit columns. At this size every row can be given a distinct pattern and read back, and copies can run between the first and last rows in both directions. Because every column position is reachable, the bench can edit a single field in the latch between the source activation and the source restore. That makes the snapshot content visibly differ from the refreshed source.

// File: rtl/rowcopy_dram_pkg.sv
package rowcopy_dram_pkg;

  // Copy sequencing phase of the bank
  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,  // no row open
    PH_OPEN       = 3'd1,  // normal row open
    PH_SRC_OPEN   = 3'd2,  // copy source open, snapshot held
    PH_SRC_CLOSED = 3'd3,  // source refreshed, waiting for destination
    PH_DST_OPEN   = 3'd4   // destination open, snapshot pending
  } cpy_phase_e;

endpackage

// File: rtl/rcu_cell_array.sv
module rcu_cell_array #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 16,
  parameter int RAW   = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [RAW-1:0]   wr_row,
  input  logic [ROW_W-1:0] wr_data,
  input  logic [RAW-1:0]   rd_row,
  output logic [ROW_W-1:0] rd_data
);

  logic [ROW_W-1:0] cells_q [ROWS];

  // One enabled register per row; storage has no reset, as in a real array
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_row == RAW'(r));
    always_ff @(posedge clk) begin
      if (row_we) begin
        cells_q[r] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rd_row == RAW'(r)) begin
        rd_data = cells_q[r];
      end
    end
  end

endmodule

// File: rtl/rcu_row_latch.sv
module rcu_row_latch #(
  parameter int ROW_W = 16,
  parameter int COL_W = 4,
  parameter int NCOL  = 4,
  parameter int CAW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [ROW_W-1:0] load_data,
  input  logic             col_wr_en,
  input  logic             col_rd_en,
  input  logic [CAW-1:0]   col_addr,
  input  logic [COL_W-1:0] col_wdata,
  output logic [COL_W-1:0] col_rdata,
  output logic [ROW_W-1:0] row_q
);

  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] rdata_q;
  logic [COL_W-1:0] rdata_d;

  // Next-state: activation load wins over a column write in the same cycle
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    always_comb begin
      if (load_en) begin
        row_d[c*COL_W +: COL_W] = load_data[c*COL_W +: COL_W];
      end else if (col_wr_en && (col_addr == CAW'(c))) begin
        row_d[c*COL_W +: COL_W] = col_wdata;
      end else begin
        row_d[c*COL_W +: COL_W] = row_q[c*COL_W +: COL_W];
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    for (int c = 0; c < NCOL; c++) begin
      if (col_rd_en && (col_addr == CAW'(c))) begin
        rdata_d = row_q[c*COL_W +: COL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      rdata_q <= '0;
    end else begin
      row_q <= row_d;
      if (col_rd_en) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign col_rdata = rdata_q;

endmodule

// File: rtl/rcu_snapshot_path.sv
module rcu_snapshot_path #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [ROW_W-1:0] cap_data,
  input  logic             sel_buf,
  input  logic [ROW_W-1:0] latch_data,
  output logic [ROW_W-1:0] wb_data
);

  logic [ROW_W-1:0] buf_q;
  logic [ROW_W-1:0] buf_d;

  always_comb begin
    buf_d = cap_en ? cap_data : buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (cap_en) begin
      buf_q <= buf_d;
    end
  end

  // Write-back selector: latch normally, snapshot for a copy write-back
  always_comb begin
    wb_data = sel_buf ? buf_q : latch_data;
  end

endmodule

// File: rtl/rcu_copy_seq.sv
module rcu_copy_seq
  import rowcopy_dram_pkg::*;
#(
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ras,
  input  logic           rw,
  input  logic           ws,
  input  logic [RAW-1:0] row_addr,
  output logic           latch_load,
  output logic           buf_load,
  output logic           wb_en,
  output logic           wb_sel_buf,
  output logic [RAW-1:0] wb_row,
  output logic           done,
  output logic           err
);

  cpy_phase_e     phase_q, phase_d;
  logic [RAW-1:0] open_q, open_d;
  logic [RAW-1:0] src_q, src_d;
  logic           pend_q, pend_d;
  logic           done_q;
  logic           err_q, err_d;

  always_comb begin
    phase_d    = phase_q;
    open_d     = open_q;
    src_d      = src_q;
    latch_load = 1'b0;
    buf_load   = 1'b0;
    wb_en      = 1'b0;
    wb_sel_buf = 1'b0;
    pend_d     = 1'b0;
    err_d      = 1'b0;
    if (ras) begin
      latch_load = 1'b1;
      open_d     = row_addr;
      if (phase_q == PH_SRC_CLOSED) begin
        if (row_addr == src_q) begin
          err_d   = 1'b1;
          phase_d = PH_OPEN;
        end else begin
          phase_d = PH_DST_OPEN;
        end
      end else if (ws) begin
        buf_load = 1'b1;
        src_d    = row_addr;
        phase_d  = PH_SRC_OPEN;
      end else begin
        phase_d = PH_OPEN;
      end
    end else if (rw) begin
      case (phase_q)
        PH_OPEN: begin
          wb_en   = 1'b1;
          phase_d = PH_IDLE;
        end
        PH_SRC_OPEN: begin
          wb_en   = 1'b1;
          phase_d = PH_SRC_CLOSED;
        end
        PH_DST_OPEN: begin
          wb_en   = 1'b1;
          phase_d = PH_IDLE;
          if (ws) begin
            wb_sel_buf = 1'b1;
            pend_d     = 1'b1;
          end
        end
        default: begin
          phase_d = phase_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      open_q  <= '0;
      src_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (ras) begin
        open_q <= open_d;
      end
      if (buf_load) begin
        src_q <= src_d;
      end
      pend_q <= pend_d;
      done_q <= pend_q;
      err_q  <= err_d;
    end
  end

  assign wb_row = open_q;
  assign done   = done_q;
  assign err    = err_q;

endmodule

// File: rtl/rowcopy_dram_bank.sv
module rowcopy_dram_bank #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 16,
  parameter int COL_W = 4,
  localparam int NCOL = ROW_W / COL_W,
  localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAW  = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAW-1:0]   row_addr_i,
  input  logic             ras_i,
  input  logic             rw_i,
  input  logic             ws_i,
  input  logic [CAW-1:0]   col_addr_i,
  input  logic             col_rd_i,
  input  logic             col_wr_i,
  input  logic [COL_W-1:0] col_wdata_i,
  output logic [COL_W-1:0] col_rdata_o,
  output logic             cpy_done_o,
  output logic             cpy_err_o
);

  logic             latch_load;
  logic             buf_load;
  logic             wb_en;
  logic             wb_sel_buf;
  logic [RAW-1:0]   wb_row;
  logic [ROW_W-1:0] array_rd;
  logic [ROW_W-1:0] latch_row;
  logic [ROW_W-1:0] wb_data;

  rcu_copy_seq #(.RAW(RAW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras        (ras_i),
    .rw         (rw_i),
    .ws         (ws_i),
    .row_addr   (row_addr_i),
    .latch_load (latch_load),
    .buf_load   (buf_load),
    .wb_en      (wb_en),
    .wb_sel_buf (wb_sel_buf),
    .wb_row     (wb_row),
    .done       (cpy_done_o),
    .err        (cpy_err_o)
  );

  rcu_cell_array #(.ROWS(ROWS), .ROW_W(ROW_W), .RAW(RAW)) array_i (
    .clk     (clk),
    .wr_en   (wb_en),
    .wr_row  (wb_row),
    .wr_data (wb_data),
    .rd_row  (row_addr_i),
    .rd_data (array_rd)
  );

  rcu_row_latch #(.ROW_W(ROW_W), .COL_W(COL_W), .NCOL(NCOL), .CAW(CAW)) latch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (latch_load),
    .load_data (array_rd),
    .col_wr_en (col_wr_i),
    .col_rd_en (col_rd_i),
    .col_addr  (col_addr_i),
    .col_wdata (col_wdata_i),
    .col_rdata (col_rdata_o),
    .row_q     (latch_row)
  );

  rcu_snapshot_path #(.ROW_W(ROW_W)) snap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (buf_load),
    .cap_data   (array_rd),
    .sel_buf    (wb_sel_buf),
    .latch_data (latch_row),
    .wb_data    (wb_data)
  );

endmodule

// File: rtl/rowcopy_dram_bank_chk.sv
module rowcopy_dram_bank_chk #(
  parameter int COL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_i,
  input logic             rw_i,
  input logic             ws_i,
  input logic             col_rd_i,
  input logic [COL_W-1:0] col_rdata_o,
  input logic             cpy_done_o,
  input logic             cpy_err_o
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpy_done_o |=> !cpy_done_o);

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpy_done_o |-> $past(rw_i && ws_i, 2));

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpy_err_o |=> !cpy_err_o);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpy_err_o |-> $past(ras_i));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(col_rdata_o) |-> $past(col_rd_i));

endmodule

bind rowcopy_dram_bank rowcopy_dram_bank_chk #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ras_i       (ras_i),
  .rw_i        (rw_i),
  .ws_i        (ws_i),
  .col_rd_i    (col_rd_i),
  .col_rdata_o (col_rdata_o),
  .cpy_done_o  (cpy_done_o),
  .cpy_err_o   (cpy_err_o)
);

// File: tb/rowcopy_dram_bank_tb.sv
module rowcopy_dram_bank_tb_top;

  localparam int ROWS  = 16;
  localparam int ROW_W = 16;
  localparam int COL_W = 4;
  localparam int NCOL  = ROW_W / COL_W;

  logic clk;
  logic rst_n;
  logic [3:0] row_addr;
  logic ras, rw, ws, col_rd, col_wr;
  logic [1:0] col_addr;
  logic [COL_W-1:0] col_wdata;
  logic [COL_W-1:0] col_rdata;
  logic done, err;

  int n_chk;
  int n_bad;
  logic [ROW_W-1:0] model [ROWS];

  rowcopy_dram_bank dut_i (
    .clk(clk), .rst_n(rst_n), .row_addr_i(row_addr), .ras_i(ras), .rw_i(rw),
    .ws_i(ws), .col_addr_i(col_addr), .col_rd_i(col_rd), .col_wr_i(col_wr),
    .col_wdata_i(col_wdata), .col_rdata_o(col_rdata), .cpy_done_o(done),
    .cpy_err_o(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic op_act(input int r, input logic w);
    ras = 1'b1; row_addr = 4'(r); ws = w;
    @(negedge clk);
    ras = 1'b0; ws = 1'b0;
  endtask

  task automatic op_restore(input logic w);
    rw = 1'b1; ws = w;
    @(negedge clk);
    rw = 1'b0; ws = 1'b0;
  endtask

  task automatic op_wr(input int c, input logic [COL_W-1:0] d);
    col_wr = 1'b1; col_addr = 2'(c); col_wdata = d;
    @(negedge clk);
    col_wr = 1'b0;
  endtask

  task automatic op_rd(input int c, output logic [COL_W-1:0] d);
    col_rd = 1'b1; col_addr = 2'(c);
    @(negedge clk);
    col_rd = 1'b0;
    d = col_rdata;
  endtask

  function automatic logic [ROW_W-1:0] set_col(input logic [ROW_W-1:0] v, input int c,
                                               input logic [COL_W-1:0] d);
    logic [ROW_W-1:0] t;
    t = v;
    t[c*COL_W +: COL_W] = d;
    return t;
  endfunction

  task automatic write_row(input int r, input logic [ROW_W-1:0] v);
    op_act(r, 1'b0);
    for (int c = 0; c < NCOL; c++) op_wr(c, v[c*COL_W +: COL_W]);
    op_restore(1'b0);
    model[r] = v;
  endtask

  task automatic read_row(input int r, output logic [ROW_W-1:0] v);
    logic [COL_W-1:0] d;
    op_act(r, 1'b0);
    for (int c = 0; c < NCOL; c++) begin
      op_rd(c, d);
      v[c*COL_W +: COL_W] = d;
    end
    op_restore(1'b0);
  endtask

  task automatic check_row(input string req, input int r);
    logic [ROW_W-1:0] v;
    read_row(r, v);
    chk(req, {16'h0, v}, {16'h0, model[r]});
  endtask

  // Done must be low now, high one cycle later, low after that
  task automatic check_done_pulse(input string req, input logic expect_pulse);
    chk(req, {31'h0, done}, 32'h0);
    @(negedge clk);
    chk(req, {31'h0, done}, {31'h0, expect_pulse});
    @(negedge clk);
    chk(req, {31'h0, done}, 32'h0);
  endtask

  task automatic t_reset;
    // R1
    chk("R1 rdata", {28'h0, col_rdata}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);
    chk("R1 err", {31'h0, err}, 32'h0);
  endtask

  task automatic t_fill_and_fields;
    logic [COL_W-1:0] d;
    for (int r = 0; r < ROWS; r++) write_row(r, 16'((r * 16'h1357) ^ 16'hA5C3));
    // R2: rows at both ends and the middle read back
    check_row("R2 row0", 0);
    check_row("R2 row15", 15);
    check_row("R2 row7", 7);
    // R2: field positions within the row
    write_row(3, 16'h4321);
    op_act(3, 1'b0);
    op_rd(0, d); chk("R2 col0", {28'h0, d}, 32'h1);
    op_rd(3, d); chk("R2 col3", {28'h0, d}, 32'h4);
    op_rd(2, d); chk("R2 col2", {28'h0, d}, 32'h3);
    op_restore(1'b0);
  endtask

  task automatic t_latch_only;
    logic [COL_W-1:0] d;
    // R3: edit without restore is lost on re-activation
    op_act(5, 1'b0);
    op_wr(1, ~model[5][7:4]);
    op_act(5, 1'b0);
    op_rd(1, d);
    chk("R3 discard", {28'h0, d}, {28'h0, model[5][7:4]});
    op_restore(1'b0);
    check_row("R3 unchanged", 5);
    // R3: edit with restore is kept
    op_act(5, 1'b0);
    op_wr(1, 4'h6);
    op_restore(1'b0);
    model[5] = set_col(model[5], 1, 4'h6);
    check_row("R3 restore", 5);
  endtask

  task automatic t_copy(input int s, input int t, input logic edit);
    logic [ROW_W-1:0] snap;
    snap = model[s];
    // R4: source activation with copy select
    op_act(s, 1'b1);
    if (edit) begin
      op_wr(0, ~snap[3:0]);
      model[s] = set_col(model[s], 0, ~snap[3:0]);
    end
    op_restore(1'b0);
    op_act(t, 1'b0);
    chk("R7 no err on valid copy", {31'h0, err}, 32'h0);
    op_restore(1'b1);
    // R6
    check_done_pulse("R6 done", 1'b1);
    model[t] = snap;
    // R5: destination gets snapshot
    check_row("R5 dest", t);
    // R4: source refreshed with edits
    check_row("R4 src", s);
  endtask

  task automatic t_same_row;
    // R7: destination equals source
    op_act(4, 1'b1);
    op_restore(1'b0);
    op_act(4, 1'b0);
    chk("R7 err high", {31'h0, err}, 32'h1);
    @(negedge clk);
    chk("R7 err low", {31'h0, err}, 32'h0);
    op_restore(1'b1);
    check_done_pulse("R7 no done", 1'b0);
    check_row("R7 row unchanged", 4);
  endtask

  task automatic t_abort;
    // R8: destination restore without copy select
    op_act(6, 1'b1);
    op_restore(1'b0);
    op_act(11, 1'b0);
    op_wr(2, 4'h7);
    op_restore(1'b0);
    check_done_pulse("R8 no done", 1'b0);
    model[11] = set_col(model[11], 2, 4'h7);
    check_row("R8 dest latch", 11);
    check_row("R8 src", 6);
  endtask

  task automatic t_ws_normal;
    // R9: copy select on a normal restore
    op_act(12, 1'b0);
    op_wr(3, 4'h9);
    op_restore(1'b1);
    check_done_pulse("R9 no done", 1'b0);
    model[12] = set_col(model[12], 3, 4'h9);
    check_row("R9 row", 12);
    check_row("R9 other", 13);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; ras = 1'b0; rw = 1'b0; ws = 1'b0; col_rd = 1'b0; col_wr = 1'b0;
    row_addr = '0; col_addr = '0; col_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_fields();
    t_latch_only();
    t_copy(2, 9, 1'b1);
    t_copy(0, 15, 1'b0);
    t_copy(15, 0, 1'b1);
    check_row("R5 untouched", 10);
    t_same_row();
    t_abort();
    t_ws_normal();
    summary();
  end

endmodule